// File: doc/BRIEF.md
# Boot-gated SRAM enable decoder for a multiplexed microcontroller bus

This block sits on the external bus of an 8-bit microcontroller whose low address byte and data share one port. It captures the low address byte while the address latch strobe is high and takes the three top address lines straight from the bus. When a data write is made into the upper half of the address map (A15 = 1), the write-strobe rising edge stores the byte in a small register bank. The bank index is the low four bits of the latched address. Each such write also advances a boot-configuration counter.

The block drives the active-low chip enable of an external SRAM. After reset that enable is held off for every access. Boot software has to write thirteen configuration bytes into the upper half of the map, and the thirteenth must be 0xFF. Once that happens a sticky flag is set, and from then on the enable simply mirrors A15. The lower half of the map then belongs to the SRAM and the upper half to this block. The read and write strobes are shared with the SRAM, so the enable is the only thing that separates the two devices.

Top module: `bus_periph_dec`

## Requirements
- R1: While `ale_i` is high on a clock edge, the byte on `ad_i` is captured as the low address. A register write stores into the entry whose index is bits 3:0 of that captured address.
- R2: Whenever A15 (`a_hi_i[2]`) is 1, `ram_ce_no` is 1.
- R3: From reset until the unlock write, `ram_ce_no` is 1 for every address.
- R4: A write is taken on the first clock edge at which `wr_ni` is sampled high after having been sampled low, with A15 = 1 at that edge. Each such write advances the configuration counter. The first twelve writes leave `ram_ce_no` at 1.
- R5: The enable unlocks only when the 13th counted write carries 0xFF. If the 13th write carries another value, later writes (0xFF included) never unlock until reset, because the 4-bit counter saturates at 15.
- R6: After the unlock, `ram_ce_no` equals A15 combinationally, within the same cycle. This stays true until reset.
- R7: A write with A15 = 0 changes neither the register bank nor the configuration count.
- R8: A taken write makes the data byte appear on `cfg_regs_o[8*i +: 8]` (i = entry index) right after the write edge. All other entries keep their value, and all entries reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch strobe, high while `ad_i` carries the low address |
| ad_i | input | 8 | Multiplexed low address / data byte |
| a_hi_i | input | 3 | Address lines A13, A14, A15 (bit 2 = A15) |
| wr_ni | input | 1 | Active-low write strobe, shared with the SRAM |
| ram_ce_no | output | 1 | Active-low SRAM chip enable |
| cfg_regs_o | output | 128 | Register bank contents, entry i at bits 8*i+7:8*i |

## Verification
A counter that is off by one shows up as an enable that unlocks on the 12th or 14th write. A corrupted flag shows up as `ram_ce_no` going low at A15 = 0 before the 13th write, or failing to go low after it. Either is visible at the port in the cycle after the offending write edge. A counter that advances on lower-half writes shifts the unlock by one write. A bad bank index or enable puts the wrong byte on `cfg_regs_o` right after the same edge. Once the flag is set, an enable that fails to follow A15 is visible immediately, with no clock between.

// File: rtl/bus_periph_dec_pkg.sv
package bus_periph_dec_pkg;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned IDX_W      = 4;
  parameter int unsigned CNT_W      = 4;
  parameter int unsigned CFG_LEN    = 13;
  parameter logic [7:0]  UNLOCK_VAL = 8'hFF;
  localparam int unsigned NREG      = 1 << IDX_W;
endpackage

// File: rtl/bus_strobe.sv
module bus_strobe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              wr_ni,
  output logic [DATA_W-1:0] addr_lo_o,
  output logic              wr_rise_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_o <= '0;
      wr_q      <= 1'b1;
    end else begin
      if (ale_i) addr_lo_o <= ad_i;
      wr_q <= wr_ni;
    end
  end

  // first edge seeing the strobe released
  assign wr_rise_o = wr_ni & ~wr_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned NREG  = 1 << IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (we_i && idx_i == IDX_W'(g))          q <= data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CFG_LEN    = 13,
  parameter logic [7:0]  UNLOCK_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              enabled_o
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CFG_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      enabled_o <= 1'b0;
    end else if (we_i) begin
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (cnt_o == LAST && data_i == DATA_W'(UNLOCK_VAL)) enabled_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_periph_dec.sv
module bus_periph_dec
  import bus_periph_dec_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ale_i,
  input  logic [DATA_W-1:0]      ad_i,
  input  logic [2:0]             a_hi_i,
  input  logic                   wr_ni,
  output logic                   ram_ce_no,
  output logic [NREG*DATA_W-1:0] cfg_regs_o
);
  logic [DATA_W-1:0] addr_lo;
  logic              wr_rise;
  logic              wr_fire;
  logic [CNT_W-1:0]  cfg_cnt;
  logic              enabled_q;
  logic              a15;

  assign a15 = a_hi_i[2];

  bus_strobe #(.DATA_W(DATA_W)) i_strobe (
    .clk_i, .rst_ni, .ale_i, .ad_i, .wr_ni,
    .addr_lo_o(addr_lo), .wr_rise_o(wr_rise)
  );

  // only upper-half writes belong to this block
  assign wr_fire = wr_rise & a15;

  cfg_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_regs (
    .clk_i, .rst_ni, .we_i(wr_fire), .idx_i(addr_lo[IDX_W-1:0]),
    .data_i(ad_i), .regs_o(cfg_regs_o)
  );

  cfg_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CFG_LEN(CFG_LEN),
            .UNLOCK_VAL(UNLOCK_VAL)) i_seq (
    .clk_i, .rst_ni, .we_i(wr_fire), .data_i(ad_i),
    .cnt_o(cfg_cnt), .enabled_o(enabled_q)
  );

  assign ram_ce_no = ~enabled_q | a15;
endmodule

// File: rtl/bus_periph_dec_chk.sv
module bus_periph_dec_chk
  import bus_periph_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a15,
  input logic              ram_ce_no,
  input logic              enabled,
  input logic              wr_fire,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_LEN - 1);

  p_upper_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a15 |-> ram_ce_no);

  p_locked_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled |-> ram_ce_no);

  p_unlock_cond_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled && !(wr_fire && cnt == LAST && wr_data == UNLOCK_VAL) |=> !enabled);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == {CNT_W{1'b1}} |=> cnt == {CNT_W{1'b1}});

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled |=> enabled);

  p_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enabled |-> ram_ce_no == a15);

  p_lower_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fire |=> $stable(cnt));
endmodule

bind bus_periph_dec bus_periph_dec_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a15(a_hi_i[2]), .ram_ce_no(ram_ce_no),
  .enabled(enabled_q), .wr_fire(wr_fire), .wr_data(ad_i), .cnt(cfg_cnt)
);

// File: tb/test_bus_periph_dec.sv
`timescale 1ns/1ps
module test_bus_periph_dec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ale = 1'b0;
  logic [7:0]   ad = '0;
  logic [2:0]   a_hi = '0;
  logic         wr_n = 1'b1;
  logic         ce_n;
  logic [127:0] regs;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [16];

  typedef struct { string req; logic [7:0] exp; int idx; } item_t;
  item_t exp_q[$];
  event  mon_ev;

  always #5 clk = ~clk;

  bus_periph_dec i_bus_periph_dec (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ad_i(ad), .a_hi_i(a_hi),
    .wr_ni(wr_n), .ram_ce_no(ce_n), .cfg_regs_o(regs)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected bank entries and compares with the outputs
  initial forever begin
    @(mon_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(it.req, regs[it.idx*8 +: 8], it.exp);
    end
  end

  task automatic push_all(input string req);
    for (int i = 0; i < 16; i++) begin
      item_t it;
      it.req = req; it.idx = i; it.exp = model[i];
      exp_q.push_back(it);
    end
    -> mon_ev;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one bus write; inputs change on negedges only
  task automatic bus_wr(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    a_hi = addr[15:13]; ad = addr[7:0]; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); ad = data; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ad = 8'h00;
    if (addr[15]) model[addr[3:0]] = data;
  endtask

  task automatic ce_at(input string req, input logic [2:0] hi, input logic exp);
    a_hi = hi;
    #1;
    check(req, {7'd0, ce_n}, {7'd0, exp});
  endtask

  initial begin
    fork
      begin
        do_reset();
        ce_at("R3", 3'b000, 1'b1);
        ce_at("R3", 3'b100, 1'b1);
        push_all("R8 reset");

        // boot run: 12 writes, lower-half write at count 12 must not count
        bus_wr(16'hA081, 8'h01);
        push_all("R1 R8 first write");
        for (int k = 1; k < 12; k++) begin
          bus_wr(16'hA080 + 16'(k + 1), 8'(k * 7 + 3));
          ce_at("R4", 3'b000, 1'b1);
        end
        push_all("R8 after twelve");
        bus_wr(16'h2085, 8'hFF);
        ce_at("R7 counter", 3'b000, 1'b1);
        push_all("R7 bank");
        bus_wr(16'hA08F, 8'hFF);
        push_all("R8 unlock byte");
        ce_at("R6 low half", 3'b000, 1'b0);
        ce_at("R6 A13 set", 3'b001, 1'b0);
        ce_at("R2 upper", 3'b100, 1'b1);
        ce_at("R6 back low", 3'b011, 1'b0);
        bus_wr(16'h8003, 8'h5A);
        push_all("R1 R8 post unlock");
        ce_at("R6 sticky", 3'b000, 1'b0);

        // wrong 13th value, then extra 0xFF writes
        do_reset();
        ce_at("R3 after reset", 3'b000, 1'b1);
        push_all("R8 reset clears");
        for (int k = 0; k < 12; k++) bus_wr(16'hC000 + 16'(k), 8'hFF);
        bus_wr(16'hC00C, 8'h55);
        ce_at("R5 wrong value", 3'b000, 1'b1);
        for (int k = 0; k < 4; k++) bus_wr(16'hC00D, 8'hFF);
        ce_at("R5 saturated", 3'b000, 1'b1);
        ce_at("R2 locked upper", 3'b111, 1'b1);
        push_all("R8 second run");
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule